// File: doc/BRIEF.md
# BCD calendar counter with alarm

This block keeps the time of day as packed BCD seconds, minutes and hours, and counts whole days in a single binary counter. A one-second tick input advances the time by one second while the run bit is set. The update is sequenced by a two-state machine. `ST_IDLE` waits for a tick. The transition `T_TICK` (a tick arrives while run is 1) enters `ST_STEP`. That state lasts exactly one clock cycle and shows busy; the counters take their new values at the clock edge that ends it. The transition `T_DONE` then always returns to `ST_IDLE`.

An alarm compares the new minute, hour and day against three alarm registers at the edge where the seconds wrap to 00. Each of the three fields has its own match enable, and a disabled field counts as matching. A hit sets a sticky flag, and the interrupt line is that flag gated by an enable. A host bridge reaches every field through a byte-wide register file with one write strobe and a combinational read port. The host is expected to poll busy before it touches the calendar or alarm registers.

Top module: `bcd_cal_alarm`

## Requirements
- R1: After reset every register reads 0x00 and `irq_o` is 0.
- R2: Seconds (address 0x15) and minutes (0x16) count 0x00 to 0x59 in packed BCD, tens in bits 7:4 and ones in bits 3:0. From 0x59 each wraps to 0x00 and carries into the next field.
- R3: Hours (0x17) count 0x00 to 0x23 in BCD. From 0x23 they wrap to 0x00 and carry into the day counter.
- R4: The day counter is 15-bit binary, with bits 7:0 at 0x18 and bits 14:8 in bits 6:0 of 0x19 (bit 7 reads 0). It wraps from 0x7FFF to 0x0000.
- R5: Time advances by exactly one second per tick, and only while control bit 0 (run) at 0x14 is 1. A tick with run at 0 changes nothing.
- R6: Control bit 7 (busy) reads 1 during the single cycle that follows the cycle in which a tick was seen with run at 1, and reads 0 otherwise. Register values after the update appear in the cycle after that.
- R7: A host write to 0x15 to 0x19 during a busy cycle is ignored. Writes to the alarm registers and to the control register take effect at any time.
- R8: Alarm registers sit at 0x1A (minute), 0x1B (hour), 0x1C (day bits 7:0) and 0x1D (day bits 14:8). Control bits 3, 4 and 5 enable the minute, hour and day match. The alarm flag (control bit 2) is set at the edge where seconds wrap to 00 if every enabled field equals its new value.
- R9: The alarm flag stays set until the host writes 0x14 with bit 2 at 1. Writing bit 2 as 0 leaves the flag unchanged. If a set and a clear fall in the same cycle, the set wins.
- R10: `irq_o` is 1 exactly when the alarm flag and control bit 1 (interrupt enable) are both 1.
- R11: Registers read back what was written: seconds and minutes as 7 bits, hours as 6 bits, control bits 5:0 with bit 6 reading 0. Addresses outside 0x14 to 0x1D read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, one cycle wide |
| reg_addr_i | input | 8 | Register address |
| reg_wr_i | input | 1 | Write strobe for `reg_wdata_i` at `reg_addr_i` |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
A tick is driven in one cycle, and busy is due in the next cycle. The updated time, the alarm flag and `irq_o` are due one cycle after that. The bench therefore reads the control register in the busy cycle and compares the full register file only after the following edge. Register writes are visible in the cycle after the strobe, and reads are combinational. All samples are taken one nanosecond after a falling edge, once the address has settled. Host writes injected during the busy cycle check the write-ignore rule and the set-over-clear priority at the same edge where the model applies its step.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int REG_W  = 8;
    localparam int N_TIME = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_STEP = 1'b1
    } cal_state_e;

    localparam logic [7:0] A_CTRL  = 8'h14;
    localparam logic [7:0] A_SEC   = 8'h15;
    localparam logic [7:0] A_MIN   = 8'h16;
    localparam logic [7:0] A_HR    = 8'h17;
    localparam logic [7:0] A_DAYL  = 8'h18;
    localparam logic [7:0] A_DAYH  = 8'h19;
    localparam logic [7:0] A_AMIN  = 8'h1A;
    localparam logic [7:0] A_AHR   = 8'h1B;
    localparam logic [7:0] A_ADAYL = 8'h1C;
    localparam logic [7:0] A_ADAYH = 8'h1D;

    localparam int B_BUSY   = 7;
    localparam int B_DAY_EN = 5;
    localparam int B_HR_EN  = 4;
    localparam int B_MIN_EN = 3;
    localparam int B_FLAG   = 2;
    localparam int B_IRQ_EN = 1;
    localparam int B_RUN    = 0;

    // index 0 = seconds, 1 = minutes, 2 = hours
    localparam logic [7:0] FIELD_MAX  [N_TIME] = '{8'h59, 8'h59, 8'h23};
    localparam logic [7:0] FIELD_MASK [N_TIME] = '{8'h7F, 8'h7F, 8'h3F};
    localparam logic [7:0] FIELD_ADDR [N_TIME] = '{8'h15, 8'h16, 8'h17};
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
    parameter int         W       = 8,
    parameter logic [7:0] MAX_BCD = 8'h59
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o,
    output logic         at_max_o
);
    logic [3:0] ones;
    logic [3:0] tens;

    assign ones     = cur_i[3:0];
    assign tens     = cur_i[7:4];
    assign at_max_o = (cur_i == W'(MAX_BCD));

    always_comb begin
        if (at_max_o) begin
            nxt_o = '0;
        end else if (ones >= 4'd9) begin
            nxt_o = W'({tens + 4'd1, 4'd0});
        end else begin
            nxt_o = W'({tens, ones + 4'd1});
        end
    end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
    parameter int DAY_W = 15
) (
    input  logic [7:0]       min_i,
    input  logic [7:0]       hr_i,
    input  logic [DAY_W-1:0] day_i,
    input  logic [7:0]       amin_i,
    input  logic [7:0]       ahr_i,
    input  logic [DAY_W-1:0] aday_i,
    input  logic             min_en_i,
    input  logic             hr_en_i,
    input  logic             day_en_i,
    output logic             hit_o
);
    logic min_ok, hr_ok, day_ok;

    assign min_ok = !min_en_i || (min_i == amin_i);
    assign hr_ok  = !hr_en_i  || (hr_i  == ahr_i);
    assign day_ok = !day_en_i || (day_i == aday_i);
    assign hit_o  = min_ok && hr_ok && day_ok;
endmodule

// File: rtl/bcd_cal_alarm.sv
module bcd_cal_alarm
    import cal_pkg::*;
#(
    parameter int DAY_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [7:0] reg_addr_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       irq_o
);
    localparam int DAY_HI_W = DAY_W - 8;

    cal_state_e state_q, state_d;
    logic       busy;

    logic [7:0]       tm_q   [N_TIME];
    logic [7:0]       tm_nxt [N_TIME];
    logic [7:0]       tm_new [N_TIME];
    logic [N_TIME-1:0] tm_max;
    logic [N_TIME:0]  carry;
    logic [DAY_W-1:0] day_q, day_new;

    logic [7:0]       amin_q, ahr_q;
    logic [DAY_W-1:0] aday_q;
    logic run_q, irq_en_q, min_en_q, hr_en_q, day_en_q, flag_q;
    logic hit, ctrl_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_TICK (IDLE->STEP), T_DONE (STEP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick_i && run_q) state_d = ST_STEP;
            ST_STEP: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        busy = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_STEP: busy = 1'b1;
        endcase
    end

    assign carry[0] = 1'b1;
    for (genvar g = 0; g < N_TIME; g++) begin : g_field
        cal_bcd_field #(.W(8), .MAX_BCD(FIELD_MAX[g])) u_field (
            .cur_i   (tm_q[g]),
            .nxt_o   (tm_nxt[g]),
            .at_max_o(tm_max[g])
        );
        assign carry[g+1] = carry[g] && tm_max[g];
        assign tm_new[g]  = carry[g] ? tm_nxt[g] : tm_q[g];
    end
    assign day_new = carry[N_TIME] ? day_q + DAY_W'(1) : day_q;

    cal_alarm_match #(.DAY_W(DAY_W)) u_match (
        .min_i   (tm_new[1]),
        .hr_i    (tm_new[2]),
        .day_i   (day_new),
        .amin_i  (amin_q),
        .ahr_i   (ahr_q),
        .aday_i  (aday_q),
        .min_en_i(min_en_q),
        .hr_en_i (hr_en_q),
        .day_en_i(day_en_q),
        .hit_o   (hit)
    );

    // time-of-day and day counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TIME; i++) tm_q[i] <= '0;
            day_q <= '0;
        end else if (busy) begin
            for (int i = 0; i < N_TIME; i++) tm_q[i] <= tm_new[i];
            day_q <= day_new;
        end else if (reg_wr_i) begin
            for (int i = 0; i < N_TIME; i++)
                if (reg_addr_i == FIELD_ADDR[i]) tm_q[i] <= reg_wdata_i & FIELD_MASK[i];
            if (reg_addr_i == A_DAYL) day_q[7:0]       <= reg_wdata_i;
            if (reg_addr_i == A_DAYH) day_q[DAY_W-1:8] <= reg_wdata_i[DAY_HI_W-1:0];
        end
    end

    // alarm registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amin_q <= '0;
            ahr_q  <= '0;
            aday_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == A_AMIN)  amin_q <= reg_wdata_i & FIELD_MASK[1];
            if (reg_addr_i == A_AHR)   ahr_q  <= reg_wdata_i & FIELD_MASK[2];
            if (reg_addr_i == A_ADAYL) aday_q[7:0]       <= reg_wdata_i;
            if (reg_addr_i == A_ADAYH) aday_q[DAY_W-1:8] <= reg_wdata_i[DAY_HI_W-1:0];
        end
    end

    // control bits and sticky alarm flag
    assign ctrl_wr = reg_wr_i && (reg_addr_i == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            irq_en_q <= 1'b0;
            min_en_q <= 1'b0;
            hr_en_q  <= 1'b0;
            day_en_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                run_q    <= reg_wdata_i[B_RUN];
                irq_en_q <= reg_wdata_i[B_IRQ_EN];
                min_en_q <= reg_wdata_i[B_MIN_EN];
                hr_en_q  <= reg_wdata_i[B_HR_EN];
                day_en_q <= reg_wdata_i[B_DAY_EN];
            end
            if (busy && carry[1] && hit)             flag_q <= 1'b1;
            else if (ctrl_wr && reg_wdata_i[B_FLAG]) flag_q <= 1'b0;
        end
    end

    // read port
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_CTRL:  reg_rdata_o = {busy, 1'b0, day_en_q, hr_en_q, min_en_q,
                                    flag_q, irq_en_q, run_q};
            A_SEC:   reg_rdata_o = tm_q[0];
            A_MIN:   reg_rdata_o = tm_q[1];
            A_HR:    reg_rdata_o = tm_q[2];
            A_DAYL:  reg_rdata_o = day_q[7:0];
            A_DAYH:  reg_rdata_o = 8'(day_q[DAY_W-1:8]);
            A_AMIN:  reg_rdata_o = amin_q;
            A_AHR:   reg_rdata_o = ahr_q;
            A_ADAYL: reg_rdata_o = aday_q[7:0];
            A_ADAYH: reg_rdata_o = 8'(aday_q[DAY_W-1:8]);
            default: reg_rdata_o = '0;
        endcase
    end

    assign irq_o = flag_q && irq_en_q;
endmodule

// File: rtl/cal_alarm_sva.sv
module cal_alarm_sva #(
    parameter int DAY_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             busy,
    input logic             run_q,
    input logic             irq_en_q,
    input logic             flag_q,
    input logic [7:0]       sec_q,
    input logic [7:0]       min_q,
    input logic [7:0]       hr_q,
    input logic [DAY_W-1:0] day_q,
    input logic             reg_wr_i,
    input logic [7:0]       reg_addr_i,
    input logic [7:0]       reg_wdata_i,
    input logic             irq_o
);
    p_busy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_busy_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick_i && run_q) |=> busy);

    p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !reg_wr_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(day_q)));

    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec_q == 8'h59) |=> (sec_q == 8'h00));

    p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec_q == 8'h59 && min_q == 8'h59 && hr_q == 8'h23) |=> (hr_q == 8'h00));

    p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec_q == 8'h59 && min_q == 8'h59 && hr_q == 8'h23 && (&day_q))
        |=> (day_q == '0));

    p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (sec_q == 8'h00));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(reg_wr_i && reg_addr_i == 8'h14 && reg_wdata_i[2])) |=> flag_q);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_q || !flag_q) |-> !irq_o);
endmodule

bind bcd_cal_alarm cal_alarm_sva #(.DAY_W(DAY_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .busy       (busy),
    .run_q      (run_q),
    .irq_en_q   (irq_en_q),
    .flag_q     (flag_q),
    .sec_q      (tm_q[0]),
    .min_q      (tm_q[1]),
    .hr_q       (tm_q[2]),
    .day_q      (day_q),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .irq_o      (irq_o)
);

// File: tb/bcd_cal_alarm_bench.sv
module bcd_cal_alarm_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0]  m_sec, m_min, m_hr, m_amin, m_ahr;
    logic [14:0] m_day, m_aday;
    logic m_run, m_ien, m_men, m_hen, m_den, m_flag;

    always #2 clk = ~clk;

    bcd_cal_alarm u_bcd_cal_alarm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] top);
        if (v == top) return 8'h00;
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic logic [7:0] exp_ctrl(input logic bsy);
        return {bsy, 1'b0, m_den, m_hen, m_men, m_flag, m_ien, m_run};
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [7:0] d,
                           input logic bsy, input logic set);
        case (a)
            8'h14: begin
                m_run = d[0]; m_ien = d[1]; m_men = d[3]; m_hen = d[4]; m_den = d[5];
                if (!set && d[2]) m_flag = 1'b0;
            end
            8'h15: if (!bsy) m_sec = d & 8'h7F;
            8'h16: if (!bsy) m_min = d & 8'h7F;
            8'h17: if (!bsy) m_hr  = d & 8'h3F;
            8'h18: if (!bsy) m_day[7:0]  = d;
            8'h19: if (!bsy) m_day[14:8] = d[6:0];
            8'h1A: m_amin = d & 8'h7F;
            8'h1B: m_ahr  = d & 8'h3F;
            8'h1C: m_aday[7:0]  = d;
            8'h1D: m_aday[14:8] = d[6:0];
            default: ;
        endcase
    endtask

    // returns 1 when the alarm flag is set by this step
    function automatic logic m_step();
        logic sw, mw, hw;
        sw = (m_sec == 8'h59);
        m_sec = bcd_next(m_sec, 8'h59);
        if (sw) begin
            mw = (m_min == 8'h59);
            m_min = bcd_next(m_min, 8'h59);
            if (mw) begin
                hw = (m_hr == 8'h23);
                m_hr = bcd_next(m_hr, 8'h23);
                if (hw) m_day = m_day + 15'd1;
            end
        end
        return sw && (!m_men || m_min == m_amin) && (!m_hen || m_hr == m_ahr)
                  && (!m_den || m_day == m_aday);
    endfunction

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        wr = 1'b0;
        #1 v = rdata;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        m_write(a, d, 1'b0, 1'b0);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        rd(8'h14, v); chk({tag, " ctrl"}, 16'(v), 16'(exp_ctrl(1'b0)));
        rd(8'h15, v); chk({tag, " sec"},  16'(v), 16'(m_sec));
        rd(8'h16, v); chk({tag, " min"},  16'(v), 16'(m_min));
        rd(8'h17, v); chk({tag, " hour"}, 16'(v), 16'(m_hr));
        rd(8'h18, v); chk({tag, " dayl"}, 16'(v), 16'(m_day[7:0]));
        rd(8'h19, v); chk({tag, " dayh"}, 16'(v), 16'({1'b0, m_day[14:8]}));
        rd(8'h1A, v); chk({tag, " amin"}, 16'(v), 16'(m_amin));
        rd(8'h1B, v); chk({tag, " ahr"},  16'(v), 16'(m_ahr));
        rd(8'h1C, v); chk({tag, " adl"},  16'(v), 16'(m_aday[7:0]));
        rd(8'h1D, v); chk({tag, " adh"},  16'(v), 16'({1'b0, m_aday[14:8]}));
        chk({tag, " R10 irq"}, 16'(irq), 16'(m_flag & m_ien));
    endtask

    // one tick; optional host write placed in the busy cycle
    task automatic do_tick(input logic side, input logic [7:0] a, input logic [7:0] d);
        logic bsy, set;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        addr = 8'h14;
        bsy = m_run;
        #1 chk("R6 busy in step cycle", 16'(rdata[7]), 16'(bsy));
        if (side) begin
            addr = a; wdata = d; wr = 1'b1;
        end
        @(negedge clk);
        wr = 1'b0;
        set = 1'b0;
        if (bsy) set = m_step();
        if (set) m_flag = 1'b1;
        if (side) m_write(a, d, bsy, set);
        addr = 8'h14;
        #1 chk("R6 busy clears", 16'(rdata[7]), 16'h0);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi,
                            input logic [7:0] h, input logic [14:0] dy);
        wreg(8'h15, s); wreg(8'h16, mi); wreg(8'h17, h);
        wreg(8'h18, dy[7:0]); wreg(8'h19, {1'b0, dy[14:8]});
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'h1F2E3D4C));
        m_sec = 0; m_min = 0; m_hr = 0; m_amin = 0; m_ahr = 0; m_day = 0; m_aday = 0;
        m_run = 0; m_ien = 0; m_men = 0; m_hen = 0; m_den = 0; m_flag = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        check_all("R1 reset");

        // R11 register readback and unmapped addresses
        set_time(8'hD7, 8'hC5, 8'hD2, 15'h1234);
        wreg(8'h1A, 8'hB1); wreg(8'h1B, 8'hC9); wreg(8'h1C, 8'h5A); wreg(8'h1D, 8'hFF);
        wreg(8'h14, 8'hFA);
        check_all("R11 readback");
        rd(8'h13, v); chk("R11 unmapped 0x13", 16'(v), 16'h0);
        rd(8'h1E, v); chk("R11 unmapped 0x1E", 16'(v), 16'h0);
        wreg(8'h14, 8'h00);

        // R5 no advance while run is 0
        set_time(8'h56, 8'h34, 8'h12, 15'h0005);
        do_tick(1'b0, 8'h00, 8'h00);
        check_all("R5 stopped");

        // R2 seconds and minutes carry
        set_time(8'h58, 8'h09, 8'h01, 15'h0010);
        wreg(8'h14, 8'h01);
        do_tick(1'b0, 8'h00, 8'h00);
        check_all("R2 to 59");
        do_tick(1'b0, 8'h00, 8'h00);
        check_all("R2 wrap");
        rd(8'h16, v); chk("R2 minute carry", 16'(v), 16'h0010);

        // R3 and R4: full rollover including day wrap
        set_time(8'h59, 8'h59, 8'h23, 15'h7FFF);
        do_tick(1'b0, 8'h00, 8'h00);
        check_all("R3 R4 rollover");
        rd(8'h19, v); chk("R4 day high wrap", 16'(v), 16'h0);

        // R7 time write during busy ignored
        set_time(8'h10, 8'h20, 8'h03, 15'h0007);
        do_tick(1'b1, 8'h15, 8'h33);
        check_all("R7 busy write");
        rd(8'h15, v); chk("R7 sec kept", 16'(v), 16'h0011);

        // R8 match, R10 gating, R9 clearing
        wreg(8'h1A, 8'h05); wreg(8'h1B, 8'h02); wreg(8'h1C, 8'h03); wreg(8'h1D, 8'h00);
        wreg(8'h14, 8'h39);
        set_time(8'h59, 8'h04, 8'h02, 15'h0003);
        do_tick(1'b0, 8'h00, 8'h00);
        check_all("R8 hit");
        rd(8'h14, v); chk("R8 flag set", 16'(v[2]), 16'h1);
        chk("R10 irq masked", 16'(irq), 16'h0);
        wreg(8'h14, 8'h3B);
        chk("R10 irq on", 16'(irq), 16'h1);
        rd(8'h14, v); chk("R9 write 0 keeps flag", 16'(v[2]), 16'h1);
        wreg(8'h14, 8'h3F);
        rd(8'h14, v); chk("R9 cleared", 16'(v[2]), 16'h0);
        chk("R10 irq off", 16'(irq), 16'h0);
        set_time(8'h59, 8'h04, 8'h02, 15'h0004);
        do_tick(1'b0, 8'h00, 8'h00);
        check_all("R8 day mismatch");
        rd(8'h14, v); chk("R8 no flag", 16'(v[2]), 16'h0);

        // R9 set wins over clear in the same cycle
        set_time(8'h59, 8'h04, 8'h02, 15'h0003);
        do_tick(1'b1, 8'h14, 8'h3F);
        check_all("R9 set wins");
        rd(8'h14, v); chk("R9 flag after race", 16'(v[2]), 16'h1);
        wreg(8'h14, 8'h3F);

        // random mix
        for (int it = 0; it < 60; it++) begin
            int nt;
            logic [7:0] side_a;
            set_time(to_bcd(50 + $urandom_range(9)), to_bcd($urandom_range(59)),
                     to_bcd($urandom_range(23)), 15'($urandom_range(32767)));
            wreg(8'h1A, to_bcd($urandom_range(59)));
            wreg(8'h1B, m_hr);
            wreg(8'h1C, m_day[7:0]);
            wreg(8'h1D, {1'b0, m_day[14:8]});
            if ($urandom_range(1) == 1) wreg(8'h1A, bcd_next(m_min, 8'h59));
            wreg(8'h14, {2'b00, 3'($urandom_range(7)), $urandom_range(3) == 0,
                         1'($urandom_range(1)), 1'b1});
            nt = 1 + $urandom_range(12);
            for (int k = 0; k < nt; k++) begin
                case ($urandom_range(3))
                    0: side_a = 8'h15;
                    1: side_a = 8'h1A;
                    2: side_a = 8'h14;
                    default: side_a = 8'h18;
                endcase
                if (side_a == 8'h14)
                    do_tick(1'b1, side_a, {2'b00, 3'($urandom_range(7)),
                            1'($urandom_range(1)), 1'($urandom_range(1)), 1'b1});
                else
                    do_tick($urandom_range(1) == 1, side_a, to_bcd($urandom_range(59)));
            end
            check_all("RND R2 R8 R9");
        end

        report();
    end
endmodule